// File: doc/BRIEF.md
# Sparse-by-Dense Binary Polynomial Multiplier

This block computes the product of two binary polynomials in the ring GF(2)[x]/(x^P+1). One factor, the dense operand A, has up to P arbitrary coefficients. It is written into an internal register memory as BW-bit words. The other factor, B, is sparse. It is supplied as a short list of exponents, one for each coefficient that is set. The block never expands B. For every listed exponent e it streams A once, word by word, through a rotating alignment stage and XOR-adds the result into a double-width accumulator. The wrap-around modulo x^P+1 is folded in only when the result is read out.

A two-bit opcode, qualified by a request strobe, selects one of four operations: load operands, multiply, read the result, or clear the accumulator. Each operation ends with a one-cycle acknowledge. NCORE parallel cores share the dense operand. Exponents are dealt out to the cores in turn, each core keeps its own accumulator, and an XOR tree merges the accumulators before the fold. Successive multiplies accumulate, so a sum of products needs no extra logic.

Top module: `gfmul_sparse_dense`

## Requirements
- R1: After a multiply, the words read out equal A·B mod (x^P+1) over GF(2). Result bit i is the XOR over all listed exponents e of A[(i−e) mod P]. Words come out least significant first: word j carries result bits j·BW to j·BW+BW−1.
- R2: A multiply XOR-adds its product into the current accumulator contents. A multiply with an empty exponent list leaves the accumulator unchanged.
- R3: Exponent k of a load goes to core k mod NCORE. Each exponent costs its core W+1 cycles, where W = ceil(P/BW). Number the rising edge that samples the request as edge 1. Then ack_o is first seen high after edge m·(W+1)+2, where m = ceil(t/NCORE) and t is the number of loaded exponents.
- R4: The opcode values are 2'b00 load, 2'b01 multiply, 2'b10 read and 2'b11 clear. An opcode is taken when req_i is high and the block is idle.
- R5: A load clears the exponent list. While the load is open, each cycle with pos_vld_i appends pos_i, and each cycle with din_vld_i stores din_i as the next dense word, lowest word first. The load ends, and ack_o is high, in the cycle right after the edge that accepts the W-th word.
- R6: Bits of the last dense word at positions P and above are discarded on load. Setting them has no effect on the product.
- R7: A read delivers exactly W words, each marked by res_vld_o. ack_o is high together with the last word, and bits of that word above position P−1 read as zero. Counting the request edge as edge 1, ack_o is seen after edge W+1.
- R8: A clear sets the whole accumulator to zero. Counting the request edge as edge 1, ack_o is seen after edge W+1.
- R9: After reset, ack_o, res_vld_o and res_o are low, and a read returns all zeros.
- R10: ack_o is high for exactly one cycle per completed operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Operation request strobe |
| op_i | input | 2 | Operation code (see R4) |
| din_i | input | BW | Dense operand word |
| din_vld_i | input | 1 | Dense word valid during a load |
| pos_i | input | clog2(P) | Sparse exponent |
| pos_vld_i | input | 1 | Exponent valid during a load |
| ack_o | output | 1 | Operation complete pulse |
| res_o | output | BW | Result word |
| res_vld_o | output | 1 | Result word valid |

## Verification
The bench builds the block with P=37, BW=8 and NCORE=2, which gives W=5 words. With P not a multiple of BW, the last word carries three padding bits, so junk on load and zeros on read can both be observed. With two cores, odd and even exponent counts give different latencies, so the round-robin split shows up in the acknowledge timing. Exponents 0, P−1 and pairs that straddle a word boundary exercise the alignment shift at both ends, including the fold of bits from the top half of the accumulator.

// File: rtl/gfmul_pkg.sv
package gfmul_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_MUL   = 2'd1,
        OP_READ  = 2'd2,
        OP_CLEAR = 2'd3
    } gf_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_MUL,
        ST_READ,
        ST_CLEAR
    } gf_state_e;

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int wbits(input int v);
        return ($clog2(v) > 0) ? $clog2(v) : 1;
    endfunction
endpackage

// File: rtl/gfmul_dense_mem.sv
module gfmul_dense_mem
    import gfmul_pkg::*;
#(
    parameter int P  = 37,
    parameter int BW = 8
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  restart_i,
    input  logic                                  wr_en_i,
    input  logic [BW-1:0]                         din_i,
    output logic                                  last_o,
    output logic [((P + BW - 1) / BW)*BW-1:0]     dense_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W    = cdiv(P, BW);
    localparam int KW   = wbits(W + 1);
    localparam int PADB = W * BW - P;
    localparam logic [BW-1:0] LASTMASK = BW'({BW{1'b1}} >> PADB);

    logic [BW-1:0] words [W];
    logic [KW-1:0] ptr;
    logic          at_last;

    assign at_last = (ptr == KW'(W - 1));
    assign last_o  = wr_en_i && at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
            for (int i = 0; i < W; i++) words[i] <= '0;
        end else if (restart_i) begin
            ptr <= '0;
        end else if (wr_en_i) begin
            words[ptr] <= at_last ? (din_i & LASTMASK) : din_i;
            ptr        <= at_last ? '0 : ptr + 1'b1;
        end
    end

    always_comb begin
        for (int i = 0; i < W; i++) dense_o[i*BW +: BW] = words[i];
    end

    // R5
    ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        ptr < KW'(W));
endmodule

// File: rtl/gfmul_core.sv
module gfmul_core
    import gfmul_pkg::*;
#(
    parameter int P   = 37,
    parameter int BW  = 8,
    parameter int TPC = 4
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic [((P + BW - 1) / BW)*BW-1:0]       dense_i,
    input  logic                                    list_clr_i,
    input  logic                                    wr_en_i,
    input  logic [$clog2(P)-1:0]                    wr_pos_i,
    input  logic                                    start_i,
    input  logic                                    clr_en_i,
    input  logic [$clog2(((P + BW - 1) / BW) + 1)-1:0] clr_idx_i,
    output logic                                    busy_o,
    output logic [2*((P + BW - 1) / BW)*BW-1:0]     acc_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W    = cdiv(P, BW);
    localparam int KW   = wbits(W + 1);
    localparam int CW   = wbits(TPC + 1);
    localparam int POSW = $clog2(P);
    localparam int AW   = wbits(2 * W);
    localparam int RW   = wbits(BW);

    logic [POSW-1:0]         list [TPC];
    logic [CW-1:0]           n_q;
    logic [CW-1:0]           idx_q;
    logic [KW-1:0]           k_q;
    logic [BW-1:0]           abuf_q;
    logic                    busy_q;
    logic [BW-1:0]           acc [2*W];

    logic [(W+1)*BW-1:0]     dpad;
    logic [POSW-1:0]         e;
    logic [RW-1:0]           r;
    logic [AW-1:0]           widx;
    logic [BW-1:0]           cur;
    logic [BW-1:0]           word;

    assign dpad = {{BW{1'b0}}, dense_i};
    assign e    = (idx_q < CW'(TPC)) ? list[idx_q] : '0;
    assign r    = RW'(int'(e) % BW);
    assign widx = AW'(int'(e) / BW) + AW'(k_q);
    assign cur  = dpad[int'(k_q)*BW +: BW];
    // alignment stage: new line shifted up, parked bits of previous line shifted down
    assign word = (cur << r) | (abuf_q >> (BW - int'(r)));

    always_ff @(posedge clk) begin
        if (rst) begin
            n_q <= '0;
            for (int i = 0; i < TPC; i++) list[i] <= '0;
        end else if (list_clr_i) begin
            n_q <= '0;
        end else if (wr_en_i && (n_q < CW'(TPC))) begin
            list[n_q] <= wr_pos_i;
            n_q       <= n_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            k_q    <= '0;
            abuf_q <= '0;
        end else if (start_i) begin
            busy_q <= (n_q != '0);
            idx_q  <= '0;
            k_q    <= '0;
            abuf_q <= '0;
        end else if (busy_q) begin
            if (k_q == KW'(W)) begin
                k_q    <= '0;
                abuf_q <= '0;
                idx_q  <= idx_q + 1'b1;
                if (idx_q + 1'b1 == n_q) busy_q <= 1'b0;
            end else begin
                k_q    <= k_q + 1'b1;
                abuf_q <= cur;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 2*W; i++) acc[i] <= '0;
        end else if (clr_en_i) begin
            acc[int'(clr_idx_i)]     <= '0;
            acc[int'(clr_idx_i) + W] <= '0;
        end else if (busy_q) begin
            acc[widx] <= acc[widx] ^ word;
        end
    end

    always_comb begin
        for (int i = 0; i < 2*W; i++) acc_o[i*BW +: BW] = acc[i];
    end

    assign busy_o = busy_q;

    // R3
    busy_idx_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (idx_q < n_q));
endmodule

// File: rtl/gfmul_fold.sv
module gfmul_fold
    import gfmul_pkg::*;
#(
    parameter int P     = 37,
    parameter int BW    = 8,
    parameter int NCORE = 2
) (
    input  logic [NCORE*2*((P + BW - 1) / BW)*BW-1:0] acc_i,
    output logic [((P + BW - 1) / BW)*BW-1:0]         res_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W    = cdiv(P, BW);
    localparam int ACCB = 2 * W * BW;

    logic [ACCB-1:0] merged;

    always_comb begin
        merged = '0;
        for (int c = 0; c < NCORE; c++) merged = merged ^ acc_i[c*ACCB +: ACCB];
    end

    always_comb begin
        res_o = '0;
        for (int i = 0; i < P; i++) res_o[i] = merged[i] ^ merged[i + P];
    end
endmodule

// File: rtl/gfmul_sparse_dense.sv
module gfmul_sparse_dense
    import gfmul_pkg::*;
#(
    parameter int P     = 37,
    parameter int BW    = 8,
    parameter int NCORE = 2,
    parameter int TMAX  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_i,
    input  logic [1:0]           op_i,
    input  logic [BW-1:0]        din_i,
    input  logic                 din_vld_i,
    input  logic [$clog2(P)-1:0] pos_i,
    input  logic                 pos_vld_i,
    output logic                 ack_o,
    output logic [BW-1:0]        res_o,
    output logic                 res_vld_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W    = cdiv(P, BW);
    localparam int TPC  = cdiv(TMAX, NCORE);
    localparam int KW   = wbits(W + 1);
    localparam int PCW  = wbits(TMAX + 1);
    localparam int CSW  = wbits(NCORE);
    localparam int ACCB = 2 * W * BW;
    localparam int PADB = W * BW - P;
    localparam logic [BW-1:0] LASTMASK = BW'({BW{1'b1}} >> PADB);

    gf_state_e               state;
    logic [KW-1:0]           step;
    logic [PCW-1:0]          pcnt;
    logic [CSW-1:0]          csel;
    logic                    ack_q;
    logic                    vld_q;
    logic [BW-1:0]           res_q;

    logic [W*BW-1:0]         dense_flat;
    logic                    load_last;
    logic [NCORE-1:0]        busy_vec;
    logic [NCORE*ACCB-1:0]   acc_flat;
    logic [W*BW-1:0]         fold_res;

    logic                    idle_req;
    logic                    load_go;
    logic                    mul_go;
    logic                    din_we;
    logic                    pos_we;
    logic                    clr_en;

    assign idle_req = req_i && (state == ST_IDLE);
    assign load_go  = idle_req && (gf_op_e'(op_i) == OP_LOAD);
    assign mul_go   = idle_req && (gf_op_e'(op_i) == OP_MUL);
    assign din_we   = (state == ST_LOAD) && din_vld_i;
    assign pos_we   = (state == ST_LOAD) && pos_vld_i && (pcnt < PCW'(TMAX));
    assign clr_en   = (state == ST_CLEAR);

    gfmul_dense_mem #(.P(P), .BW(BW)) dmem_i (
        .clk       (clk),
        .rst       (rst),
        .restart_i (load_go),
        .wr_en_i   (din_we),
        .din_i     (din_i),
        .last_o    (load_last),
        .dense_o   (dense_flat)
    );

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        gfmul_core #(.P(P), .BW(BW), .TPC(TPC)) core_i (
            .clk        (clk),
            .rst        (rst),
            .dense_i    (dense_flat),
            .list_clr_i (load_go),
            .wr_en_i    (pos_we && (csel == CSW'(c))),
            .wr_pos_i   (pos_i),
            .start_i    (mul_go),
            .clr_en_i   (clr_en),
            .clr_idx_i  (step),
            .busy_o     (busy_vec[c]),
            .acc_o      (acc_flat[c*ACCB +: ACCB])
        );
    end

    gfmul_fold #(.P(P), .BW(BW), .NCORE(NCORE)) fold_i (
        .acc_i (acc_flat),
        .res_o (fold_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            step  <= '0;
            pcnt  <= '0;
            csel  <= '0;
            ack_q <= 1'b0;
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            ack_q <= 1'b0;
            vld_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_i) begin
                        step <= '0;
                        unique case (gf_op_e'(op_i))
                            OP_LOAD: begin
                                state <= ST_LOAD;
                                pcnt  <= '0;
                                csel  <= '0;
                            end
                            OP_MUL:   state <= ST_MUL;
                            OP_READ:  state <= ST_READ;
                            OP_CLEAR: state <= ST_CLEAR;
                            default:  state <= ST_IDLE;
                        endcase
                    end
                end
                ST_LOAD: begin
                    if (pos_we) begin
                        pcnt <= pcnt + 1'b1;
                        csel <= (csel == CSW'(NCORE - 1)) ? '0 : csel + 1'b1;
                    end
                    if (load_last) begin
                        state <= ST_IDLE;
                        ack_q <= 1'b1;
                    end
                end
                ST_MUL: begin
                    if (busy_vec == '0) begin
                        state <= ST_IDLE;
                        ack_q <= 1'b1;
                    end
                end
                ST_READ: begin
                    res_q <= fold_res[int'(step)*BW +: BW];
                    vld_q <= 1'b1;
                    if (step == KW'(W - 1)) begin
                        state <= ST_IDLE;
                        ack_q <= 1'b1;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                ST_CLEAR: begin
                    if (step == KW'(W - 1)) begin
                        state <= ST_IDLE;
                        ack_q <= 1'b1;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ack_o     = ack_q;
    assign res_o     = res_q;
    assign res_vld_o = vld_q;

    // R10
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o);

    // R7
    vld_src_chk: assert property (@(posedge clk) disable iff (rst)
        res_vld_o |-> ($past(state) == ST_READ));

    // R7
    pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (res_vld_o && ack_o) |-> ((res_o & ~LASTMASK) == '0));

    // R3
    idle_cores_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_MUL) |-> (busy_vec == '0));
endmodule

// File: tb/gfmul_sparse_dense_tb.sv
module gfmul_sparse_dense_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PB = 37;
    localparam int WB = 5;
    localparam int NV = 5;

    // stimulus table: dense operand, exponent count, exponents, expected multiply latency
    localparam logic [63:0] VA [NV] = '{64'h0000001A5C3E9B71, 64'h0000000000000001,
                                        64'h0000001000000000, 64'h0000000F0F0F0F0F,
                                        64'h0000001555555555};
    localparam int VT [NV]    = '{1, 4, 2, 3, 4};
    localparam int VP [NV][4] = '{'{0, 0, 0, 0}, '{3, 10, 20, 36}, '{35, 36, 0, 0},
                                  '{1, 2, 30, 0}, '{0, 8, 16, 36}};
    localparam int VL [NV]    = '{8, 14, 8, 14, 14};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic [1:0] op = 2'd0;
    logic [7:0] din = 8'd0;
    logic       din_vld = 1'b0;
    logic [5:0] pos = 6'd0;
    logic       pos_vld = 1'b0;
    logic       ack;
    logic [7:0] res;
    logic       res_vld;

    int          n_run = 0;
    int          n_fail = 0;
    logic [63:0] rd_val;
    int          rd_cnt;
    int          lat;
    logic [63:0] prev;
    logic [63:0] expv;

    always #4 clk = ~clk;

    gfmul_sparse_dense dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req),
        .op_i      (op),
        .din_i     (din),
        .din_vld_i (din_vld),
        .pos_i     (pos),
        .pos_vld_i (pos_vld),
        .ack_o     (ack),
        .res_o     (res),
        .res_vld_o (res_vld)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_mul(input logic [63:0] a, input int t,
                                            input int p0, input int p1, input int p2, input int p3);
        int pl [4];
        logic [63:0] c;
        pl = '{p0, p1, p2, p3};
        c = '0;
        for (int k = 0; k < t; k++)
            for (int i = 0; i < PB; i++)
                if (a[i]) c[(i + pl[k]) % PB] = c[(i + pl[k]) % PB] ^ 1'b1;
        return c;
    endfunction

    task automatic issue(input logic [1:0] o, output int l);
        rd_val = '0;
        rd_cnt = 0;
        l = -1;
        @(negedge clk);
        req = 1'b1;
        op  = o;
        for (int i = 1; i <= 300; i++) begin
            @(posedge clk);
            @(negedge clk);
            req = 1'b0;
            if (res_vld && rd_cnt < 8) begin
                rd_val[rd_cnt*8 +: 8] = res;
                rd_cnt++;
            end
            if (ack) begin
                l = i;
                break;
            end
        end
        if (l > 0) begin
            @(negedge clk);
            chk(ack == 1'b0, "R10 ack lasts one cycle", 64'(ack), 64'd0);
        end
    endtask

    task automatic load(input logic [63:0] a, input int t, input int p0, input int p1,
                        input int p2, input int p3, input bit junk);
        int pl [4];
        pl = '{p0, p1, p2, p3};
        @(negedge clk);
        req = 1'b1;
        op  = 2'b00;
        @(negedge clk);
        req = 1'b0;
        for (int i = 0; i < t; i++) begin
            pos     = 6'(pl[i]);
            pos_vld = 1'b1;
            @(negedge clk);
        end
        pos_vld = 1'b0;
        for (int w = 0; w < WB; w++) begin
            din = a[w*8 +: 8];
            if (junk && w == WB - 1) din = din | 8'hE0;
            din_vld = 1'b1;
            @(negedge clk);
        end
        din_vld = 1'b0;
        chk(ack == 1'b1, "R5 ack after last dense word", 64'(ack), 64'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(ack == 1'b0 && res_vld == 1'b0 && res == 8'd0, "R9 outputs low after reset",
            {55'd0, ack, res_vld, res[6:0]}, 64'd0);
        issue(2'b10, lat);
        chk(rd_val == 64'd0, "R9 accumulator zero after reset", rd_val, 64'd0);
        chk(lat == 6 && rd_cnt == WB, "R7 read word count and latency", 64'(lat), 64'd6);

        // table walk: clear, load, multiply, read
        for (int v = 0; v < NV; v++) begin
            issue(2'b11, lat);
            chk(lat == 6, "R8 clear latency", 64'(lat), 64'd6);
            load(VA[v], VT[v], VP[v][0], VP[v][1], VP[v][2], VP[v][3], 1'b0);
            issue(2'b01, lat);
            chk(lat == VL[v], "R3 multiply latency", 64'(lat), 64'(VL[v]));
            expv = ref_mul(VA[v], VT[v], VP[v][0], VP[v][1], VP[v][2], VP[v][3]);
            issue(2'b10, lat);
            chk(rd_val == expv, "R1 product value", rd_val, expv);
            chk(lat == 6 && rd_cnt == WB, "R7 read words and ack with last", 64'(rd_cnt), 64'(WB));
            prev = expv;
        end

        // R2: empty exponent list leaves the accumulator untouched
        load(64'h0000001FFFFFFFFF, 0, 0, 0, 0, 0, 1'b0);
        issue(2'b01, lat);
        chk(lat == 2, "R3 empty multiply latency", 64'(lat), 64'd2);
        issue(2'b10, lat);
        chk(rd_val == prev, "R2 empty multiply keeps accumulator", rd_val, prev);

        // R2: a second multiply XOR-adds into the accumulator
        load(VA[0], 2, 4, 9, 0, 0, 1'b0);
        issue(2'b01, lat);
        chk(lat == 8, "R3 two exponents over two cores", 64'(lat), 64'd8);
        expv = prev ^ ref_mul(VA[0], 2, 4, 9, 0, 0);
        issue(2'b10, lat);
        chk(rd_val == expv, "R2 accumulate without clear", rd_val, expv);

        // R4/R8: opcode 2'b11 clears, 2'b10 then reads zeros
        issue(2'b11, lat);
        chk(lat == 6, "R8 clear latency", 64'(lat), 64'd6);
        issue(2'b10, lat);
        chk(rd_val == 64'd0, "R4 R8 clear then read gives zero", rd_val, 64'd0);

        // R6: junk above bit P-1 in the last dense word is discarded
        load(64'h0000000A00000003, 1, 35, 0, 0, 0, 1'b1);
        issue(2'b01, lat);
        expv = ref_mul(64'h0000000A00000003, 1, 35, 0, 0, 0);
        issue(2'b10, lat);
        chk(rd_val == expv, "R6 padding bits ignored", rd_val, expv);
        chk(rd_val[39:37] == 3'd0, "R7 last word padding zero", 64'(rd_val[39:37]), 64'd0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule